// File: doc/BRIEF.md
# Dual-Mode Microcontroller Parallel Host Port

This block is the host-facing write/read port of a display controller. A microcontroller reaches it over an 8-bit bus together with a chip select, two strobe pins and a data/command select. A static mode input picks one of two strobe conventions. In the 68-style convention, one pin is a high-active enable and the other selects read (high) or write (low). In the 80-style convention, the two pins are separate active-low read and write strobes.

Every host pin is brought into the internal clock domain through a two-flop synchroniser. A small state machine then follows each transfer from start to finish. A finished write delivers its byte on one of two outputs, each with a one-cycle valid pulse. The command output is used when the data/command select was low, and the display-data output when it was high. During a read the port enables its bus driver and presents a byte supplied by the controller on a status input.

The bidirectional bus is split into an input, an output and an output enable, which the pad ring combines.

The state machine has four states:
- `ST_IDLE`: waiting for a transfer.
- `ST_WRITE`: a write strobe is active.
- `ST_READ`: a read strobe is active and the bus driver is on.
- `ST_DRAIN`: waiting for the strobes to return to their idle level.

Its transitions are:
- start-write: `ST_IDLE` to `ST_WRITE`.
- start-read: `ST_IDLE` to `ST_READ`.
- commit: `ST_WRITE` to `ST_IDLE`, which issues the valid pulse.
- abort: `ST_WRITE` to `ST_DRAIN`, taken when chip select leaves before the strobe ends.
- read-end: `ST_READ` to `ST_IDLE`.
- settle: `ST_DRAIN` to `ST_IDLE`.

Reset enters `ST_DRAIN`.

Top module: `mpi_host_port`

## Requirements
- R1: While `cs_n` is high, strobe activity produces no valid pulse and `bus_oe` stays 0.
- R2: With `mode_sel`=0 (68-style), `stb_a` high and `stb_b` high with `cs_n` low is a read. `bus_oe` goes to 1 and `bus_out` equals `rd_data` from the third rising clock edge after `stb_a` rises. `bus_oe` drops on the third edge after `stb_a` falls.
- R3: With `mode_sel`=0, `stb_a` high and `stb_b` low with `cs_n` low is a write. The byte is the bus value seen while `stb_a` was still high. A bus change made together with the fall of `stb_a` is not taken. The valid pulse starts on the third rising edge after `stb_a` falls.
- R4: With `mode_sel`=1 (80-style), `stb_a` low (active-low read strobe) with `cs_n` low is a read. `bus_oe` and `bus_out` follow the same three-edge timing as R2.
- R5: With `mode_sel`=1, `stb_b` low (active-low write strobe) with `cs_n` low is a write. The byte seen while `stb_b` was low is delivered, with its valid pulse on the third rising edge after `stb_b` rises. A bus change made together with the rise of `stb_b` is not taken.
- R6: A write with `dc_sel` low raises `cmd_valid` with the byte on `cmd_byte`. A write with `dc_sel` high raises `pix_valid` with the byte on `pix_byte`. The other valid stays 0.
- R7: Each completed write gives exactly one valid pulse, one clock cycle long.
- R8: With `mode_sel`=1, if both strobes are low at once, the write wins: `bus_oe` stays 0 and the byte is delivered when the strobes are released.
- R9: If `cs_n` rises while a write strobe is active, the write is dropped. No pulse follows, even when the strobe later ends. The port accepts new transfers once the strobes are idle.
- R10: While `rst_n` is low, `bus_oe`, `cmd_valid`, `pix_valid`, `cmd_byte` and `pix_byte` are 0. A strobe still active when reset is released gives no transfer.
- R11: `bus_out` is 0 whenever `bus_oe` is 0, and follows `rd_data` while `bus_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | Static convention select: 0 = 68-style, 1 = 80-style |
| cs_n | input | 1 | Active-low chip select |
| stb_a | input | 1 | 68-style: high-active enable; 80-style: active-low read strobe |
| stb_b | input | 1 | 68-style: read (1) / write (0) select; 80-style: active-low write strobe |
| dc_sel | input | 1 | 0 = command byte, 1 = display-data byte |
| bus_in | input | 8 | Host bus, input half |
| bus_out | output | 8 | Host bus, output half |
| bus_oe | output | 1 | Drive enable for the host bus |
| rd_data | input | 8 | Byte returned to the host on a read |
| cmd_byte | output | 8 | Last command byte written |
| cmd_valid | output | 1 | One-cycle pulse for a new command byte |
| pix_byte | output | 8 | Last display-data byte written |
| pix_valid | output | 1 | One-cycle pulse for a new display-data byte |

## Verification
Every result is due on the third rising clock edge after the host pin change that causes it. Two edges go through the synchroniser, and the third registers the state and the valid pulse. The bench therefore drives pins on falling edges and samples on the third falling edge afterwards. It also samples on the falling edge one before that, to confirm the result has not appeared early, and on the falling edge one after, to confirm the pulse is only one cycle long. A free-running pulse counter covers the cases where the requirement is that nothing happens, or that exactly one thing happens, over a longer window.

// File: rtl/mpi_pkg.sv
package mpi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_DRAIN = 2'd3
    } port_state_e;

    // Strobe conditions after mode normalisation
    typedef struct packed {
        logic wr_start;
        logic rd_start;
        logic wr_done;
        logic rd_done;
        logic quiet;
    } strobe_t;

endpackage

// File: rtl/mpi_sync.sv
module mpi_sync #(
    parameter int                WIDTH   = 1,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            logic [WIDTH-1:0] r;
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) r <= RST_VAL;
                    else        r <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) r <= RST_VAL;
                    else        r <= g_stage[i-1].r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/mpi_strobe_decode.sv
module mpi_strobe_decode
    import mpi_pkg::*;
(
    input  logic    mode_sel,
    input  logic    s_cs_n,
    input  logic    s_a,
    input  logic    s_b,
    output strobe_t stb
);

    always_comb begin
        if (!mode_sel) begin
            // 68-style: s_a is enable (high active), s_b is read/not-write
            stb.wr_start = !s_cs_n && s_a && !s_b;
            stb.rd_start = !s_cs_n && s_a &&  s_b;
            stb.wr_done  = !s_a;
            stb.rd_done  = !s_a;
            stb.quiet    = !s_a;
        end else begin
            // 80-style: s_a is read strobe, s_b is write strobe (both low active)
            stb.wr_start = !s_cs_n && !s_b;
            stb.rd_start = !s_cs_n && !s_a && s_b;
            stb.wr_done  = s_b;
            stb.rd_done  = s_a;
            stb.quiet    = s_a && s_b;
        end
    end

endmodule

// File: rtl/mpi_port_fsm.sv
module mpi_port_fsm
    import mpi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        s_cs_n,
    input  strobe_t     stb,
    output port_state_e state,
    output logic        commit,
    output logic        capture
);

    port_state_e state_nx;

    // State register; reset lands in drain so a live strobe is not taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DRAIN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (stb.wr_start)      state_nx = ST_WRITE;   // start-write
                else if (stb.rd_start) state_nx = ST_READ;    // start-read
            end
            ST_WRITE: begin
                if (s_cs_n)            state_nx = ST_DRAIN;   // abort
                else if (stb.wr_done)  state_nx = ST_IDLE;    // commit
            end
            ST_READ: begin
                if (s_cs_n || stb.rd_done) state_nx = ST_IDLE; // read-end
            end
            ST_DRAIN: begin
                if (stb.quiet)         state_nx = ST_IDLE;    // settle
            end
            default:                   state_nx = ST_DRAIN;
        endcase
    end

    assign commit  = (state == ST_WRITE) && !s_cs_n && stb.wr_done;
    assign capture = ((state == ST_IDLE) && stb.wr_start) ||
                     ((state == ST_WRITE) && !s_cs_n && !stb.wr_done);

endmodule

// File: rtl/mpi_port_out.sv
module mpi_port_out
    import mpi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_state_e       state,
    input  logic              commit,
    input  logic              capture,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_dc,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] pix_byte,
    output logic              pix_valid
);

    logic [DATA_W-1:0] hold_byte;
    logic              hold_dc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_byte <= '0;
            hold_dc   <= 1'b0;
            cmd_byte  <= '0;
            pix_byte  <= '0;
            cmd_valid <= 1'b0;
            pix_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            pix_valid <= 1'b0;
            if (capture) begin
                hold_byte <= s_data;
                hold_dc   <= s_dc;
            end
            if (commit) begin
                if (hold_dc) begin
                    pix_byte  <= hold_byte;
                    pix_valid <= 1'b1;
                end else begin
                    cmd_byte  <= hold_byte;
                    cmd_valid <= 1'b1;
                end
            end
        end
    end

    assign bus_oe  = (state == ST_READ);
    assign bus_out = bus_oe ? rd_data : '0;

endmodule

// File: rtl/mpi_host_port.sv
module mpi_host_port
    import mpi_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              cs_n,
    input  logic              stb_a,
    input  logic              stb_b,
    input  logic              dc_sel,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] pix_byte,
    output logic              pix_valid
);

    localparam int SYNC_W = DATA_W + 4;
    // cs_n idle high, stb_a high / stb_b low look "busy" in both conventions
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b1, 1'b0, 1'b0, {DATA_W{1'b0}}};

    logic [SYNC_W-1:0] raw_pins;
    logic [SYNC_W-1:0] s_pins;
    logic              s_cs_n;
    logic              s_a;
    logic              s_b;
    logic              s_dc;
    logic [DATA_W-1:0] s_data;
    strobe_t           stb;
    port_state_e       state;
    logic              commit;
    logic              capture;

    assign raw_pins = {cs_n, stb_a, stb_b, dc_sel, bus_in};

    mpi_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_pins),
        .q     (s_pins)
    );

    assign {s_cs_n, s_a, s_b, s_dc, s_data} = s_pins;

    mpi_strobe_decode u_dec (
        .mode_sel (mode_sel),
        .s_cs_n   (s_cs_n),
        .s_a      (s_a),
        .s_b      (s_b),
        .stb      (stb)
    );

    mpi_port_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_cs_n  (s_cs_n),
        .stb     (stb),
        .state   (state),
        .commit  (commit),
        .capture (capture)
    );

    mpi_port_out #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .commit    (commit),
        .capture   (capture),
        .s_data    (s_data),
        .s_dc      (s_dc),
        .rd_data   (rd_data),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .cmd_byte  (cmd_byte),
        .cmd_valid (cmd_valid),
        .pix_byte  (pix_byte),
        .pix_valid (pix_valid)
    );

endmodule

// File: rtl/mpi_host_port_chk.sv
module mpi_host_port_chk
    import mpi_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_oe,
    input logic        cmd_valid,
    input logic        pix_valid,
    input logic        s_cs_n,
    input port_state_e state
);

    AST_VALID_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && pix_valid)); // R6

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R7

    AST_PIX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid); // R7

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !$past(s_cs_n)); // R1

    AST_VALID_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || pix_valid) |-> !$past(s_cs_n)); // R9

    AST_VALID_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || pix_valid) |-> ($past(state) == ST_WRITE)); // R3

    AST_NO_OE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !(cmd_valid || pix_valid)); // R8

endmodule

bind mpi_host_port mpi_host_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_oe    (bus_oe),
    .cmd_valid (cmd_valid),
    .pix_valid (pix_valid),
    .s_cs_n    (s_cs_n),
    .state     (state)
);

// File: tb/tb_mpi_host_port.sv
`timescale 1ns/1ps
module tb_mpi_host_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0;
    logic       cs_n = 1'b1;
    logic       stb_a = 1'b0;
    logic       stb_b = 1'b1;
    logic       dc_sel = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [7:0] rd_data = 8'h00;
    logic [7:0] cmd_byte;
    logic       cmd_valid;
    logic [7:0] pix_byte;
    logic       pix_valid;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mpi_host_port dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
        .stb_a(stb_a), .stb_b(stb_b), .dc_sel(dc_sel), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .rd_data(rd_data),
        .cmd_byte(cmd_byte), .cmd_valid(cmd_valid),
        .pix_byte(pix_byte), .pix_valid(pix_valid)
    );

    always @(posedge clk) if (cmd_valid || pix_valid) pulses++;

    // {flip[11], mode[10], read[9], dc[8], data[7:0]}
    localparam logic [11:0] VEC [8] = '{
        12'h0AE, 12'h95A, 12'h23C, 12'h1FF,
        12'h400, 12'hDA5, 12'h6C3, 12'h481
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nedge(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic go_idle();
        cs_n  = 1'b1;
        stb_a = mode_sel;   // 68: enable low; 80: read strobe high
        stb_b = 1'b1;
    endtask

    task automatic apply_reset(input logic m);
        @(negedge clk);
        rst_n = 1'b0;
        mode_sel = m;
        go_idle();
        nedge(3);
        rst_n = 1'b1;
        nedge(4);
    endtask

    task automatic do_write(input logic dc, input logic [7:0] d, input bit flip);
        int p0;
        string tg;
        tg = mode_sel ? "R5" : "R3";
        @(negedge clk);
        cs_n = 1'b0; dc_sel = dc; bus_in = d;
        if (!mode_sel) begin stb_a = 1'b1; stb_b = 1'b0; end
        else           stb_b = 1'b0;
        nedge(4);
        p0 = pulses;
        if (!mode_sel) stb_a = 1'b0; else stb_b = 1'b1;
        if (flip) bus_in = ~d;
        nedge(2);
        chk(!cmd_valid && !pix_valid, {tg, " pulse not yet"}, {cmd_valid, pix_valid}, 0);
        nedge(1);
        chk(cmd_valid == !dc && pix_valid == dc, "R6 valid routing",
            {cmd_valid, pix_valid}, {!dc, dc});
        chk((dc ? pix_byte : cmd_byte) == d, {tg, " captured byte"},
            dc ? pix_byte : cmd_byte, d);
        nedge(1);
        chk(!cmd_valid && !pix_valid, "R7 pulse one cycle", {cmd_valid, pix_valid}, 0);
        go_idle();
        nedge(3);
        chk(pulses == p0 + 1, "R7 one pulse per write", pulses - p0, 1);
    endtask

    task automatic do_read(input logic [7:0] d);
        int p0;
        string tg;
        tg = mode_sel ? "R4" : "R2";
        p0 = pulses;
        @(negedge clk);
        rd_data = d;
        cs_n = 1'b0;
        if (!mode_sel) begin stb_a = 1'b1; stb_b = 1'b1; end
        else           stb_a = 1'b0;
        nedge(2);
        chk(!bus_oe, {tg, " oe not yet"}, bus_oe, 0);
        nedge(1);
        chk(bus_oe && bus_out == d, {tg, " read data"}, {bus_oe, bus_out}, {1'b1, d});
        rd_data = ~d;
        nedge(1);
        chk(bus_out == ~d, "R11 bus follows rd_data", bus_out, ~d);
        if (!mode_sel) stb_a = 1'b0; else stb_a = 1'b1;
        nedge(2);
        chk(bus_oe, {tg, " oe held"}, bus_oe, 1);
        nedge(1);
        chk(!bus_oe && bus_out == 8'h00, "R11 bus quiet after read", {bus_oe, bus_out}, 0);
        go_idle();
        nedge(2);
        chk(pulses == p0, {tg, " read gives no pulse"}, pulses - p0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int cur_mode;
        int p0;
        cur_mode = -1;

        // R10 reset state
        nedge(2);
        chk(!bus_oe && !cmd_valid && !pix_valid, "R10 outputs in reset",
            {bus_oe, cmd_valid, pix_valid}, 0);
        apply_reset(1'b0);
        cur_mode = 0;
        chk(cmd_byte == 0 && pix_byte == 0 && bus_out == 0, "R10 bytes after reset",
            {cmd_byte, pix_byte}, 0);

        // Vector table
        for (int v = 0; v < 8; v++) begin
            if (int'(VEC[v][10]) != cur_mode) begin
                apply_reset(VEC[v][10]);
                cur_mode = int'(VEC[v][10]);
            end
            if (VEC[v][9]) do_read(VEC[v][7:0]);
            else           do_write(VEC[v][8], VEC[v][7:0], VEC[v][11]);
        end

        // R1: chip select high, strobes moving (68-style)
        apply_reset(1'b0);
        p0 = pulses;
        @(negedge clk);
        stb_a = 1'b1; stb_b = 1'b0; bus_in = 8'h11;
        nedge(4);
        stb_a = 1'b0;
        nedge(5);
        chk(pulses == p0, "R1 no write without cs", pulses - p0, 0);
        stb_a = 1'b1; stb_b = 1'b1;
        nedge(4);
        chk(!bus_oe, "R1 no read without cs", bus_oe, 0);
        go_idle();
        nedge(3);

        // R9: chip select leaves mid-write
        p0 = pulses;
        @(negedge clk);
        cs_n = 1'b0; stb_a = 1'b1; stb_b = 1'b0; bus_in = 8'h77; dc_sel = 1'b0;
        nedge(4);
        cs_n = 1'b1;
        nedge(4);
        stb_a = 1'b0;
        nedge(5);
        chk(pulses == p0, "R9 aborted write dropped", pulses - p0, 0);
        go_idle();
        nedge(2);
        do_write(1'b1, 8'h3E, 1'b0);
        chk(pix_byte == 8'h3E, "R9 port usable after abort", pix_byte, 8'h3E);

        // R10: reset in the middle of a write, strobe still high on release
        p0 = pulses;
        @(negedge clk);
        cs_n = 1'b0; stb_a = 1'b1; stb_b = 1'b0; bus_in = 8'h99; dc_sel = 1'b0;
        nedge(4);
        rst_n = 1'b0;
        nedge(1);
        chk(!bus_oe && !cmd_valid && !pix_valid && cmd_byte == 0 && pix_byte == 0,
            "R10 mid-write reset clears", {cmd_byte, pix_byte}, 0);
        nedge(2);
        rst_n = 1'b1;
        nedge(5);
        stb_a = 1'b0;
        nedge(5);
        chk(pulses == p0, "R10 no transfer from stale strobe", pulses - p0, 0);
        go_idle();
        nedge(2);
        do_write(1'b0, 8'h5C, 1'b0);

        // R8: 80-style with both strobes low
        apply_reset(1'b1);
        p0 = pulses;
        @(negedge clk);
        cs_n = 1'b0; stb_a = 1'b0; stb_b = 1'b0; bus_in = 8'hE7; dc_sel = 1'b1;
        nedge(4);
        chk(!bus_oe, "R8 write wins over read", bus_oe, 0);
        stb_a = 1'b1; stb_b = 1'b1;
        nedge(3);
        chk(pix_valid && pix_byte == 8'hE7, "R8 byte delivered", pix_byte, 8'hE7);
        go_idle();
        nedge(3);
        chk(pulses == p0 + 1, "R8 single pulse", pulses - p0, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule